// File: doc/BRIEF.md
# Statistics Counter Bank

This block keeps the receive and transmit statistics of a network port as 32-bit counters in a single synchronous RAM. At the end of every frame, the receive path and the transmit path each present a one-cycle event. The event carries the frame length, the destination class, the error flags and a PAUSE marker. The block holds the event and turns it into a short series of read-modify-write updates, one for each counter the frame touches. It writes these updates one after another, so several counters can change for the same frame without loss.

A host reads any counter with a level handshake. It places a 6-bit counter address on the read-address input and raises an apply input. When the RAM is free, the block reads the counter and raises grant. The value then appears as two 16-bit halves. Frame updates always win the RAM over host reads. A waiting read takes the first cycle in which no update is queued. After reset, the block spends one cycle on each of the 64 RAM words to clear it. Until that sweep is done it serves neither events nor reads, and no event may arrive during it. Two events of the same direction must be at least 34 cycles apart. Counters wrap modulo 2^32.

Top module: `stat_bank`

## Requirements
- R1: After reset, rd_grant is 0, and once the clearing sweep is done every counter reads 0.
- R2: With no update queued, rd_grant rises on the second rising clock edge after rd_apply is first sampled high. rd_data_lo and rd_data_hi then show bits 15:0 and 31:16 of the counter at rd_addr, and both stay unchanged while rd_apply and rd_grant stay high.
- R3: rd_grant returns to 0 on the first rising edge at which rd_apply is sampled low. Another read needs rd_apply low and then high again.
- R4: Receive counters start at address 0x00 and transmit counters at 0x20. For every frame, offset 0 adds the frame length and offset 1 adds one.
- R5: Every frame adds one to exactly one destination-class counter. Class code 2'b10 (broadcast) goes to offset 2, 2'b01 (multicast) to offset 3, and 2'b00 or 2'b11 (unicast) to offset 4.
- R6: Every frame adds one to exactly one length bin. Length below 64 goes to offset 8, exactly 64 to offset 9, 65–127 to offset 10, 128–255 to offset 11, 256–511 to offset 12, 512–1023 to offset 13, 1024–1517 to offset 14, and 1518 or more to offset 15.
- R7: Each error flag that is set adds one to its own counter, independently of the others. Receive: CRC error at offset 5, FIFO full at offset 6, length violation at offset 7. Transmit: jam drop at offset 5, FIFO underflow at offset 6, FIFO overflow at offset 7.
- R8: A frame marked PAUSE adds one at offset 16 and is also counted by R4, R5 and R6.
- R9: A receive event and a transmit event in the same cycle are both fully counted.
- R10: A host read raised while a frame's updates are still queued is served only after all of them are written. It therefore returns the updated value, and its grant comes later than the R2 latency.
- R11: Addresses with no counter (0x11–0x1F and 0x31–0x3F) always read 0 and are never changed by frame events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_frame_valid | input | 1 | One-cycle end-of-frame event from the receive path |
| rx_frame_len | input | 16 | Receive frame length in bytes |
| rx_frame_class | input | 2 | Receive destination class (10 broadcast, 01 multicast, else unicast) |
| rx_crc_err | input | 1 | Receive frame had a CRC error |
| rx_fifo_full | input | 1 | Receive FIFO was full |
| rx_len_err | input | 1 | Receive frame too short or too long |
| rx_pause | input | 1 | Receive frame was a PAUSE frame |
| tx_frame_valid | input | 1 | One-cycle end-of-frame event from the transmit path |
| tx_frame_len | input | 16 | Transmit frame length in bytes |
| tx_frame_class | input | 2 | Transmit destination class, same coding as receive |
| tx_jam_drop | input | 1 | Transmit frame dropped after too many collisions |
| tx_underflow | input | 1 | Transmit FIFO ran empty |
| tx_overflow | input | 1 | Transmit FIFO overflowed |
| tx_pause | input | 1 | Transmit frame was a PAUSE frame |
| rd_addr | input | 6 | Counter address for a host read |
| rd_apply | input | 1 | Host read request, held high until done |
| rd_grant | output | 1 | Read value is valid |
| rd_data_lo | output | 16 | Bits 15:0 of the counter read |
| rd_data_hi | output | 16 | Bits 31:16 of the counter read |

## Verification
The main stimulus is a table of frames from both directions. Their lengths sit on each side of every bin threshold, so an off-by-one bin boundary shows up in a neighbouring bin's count. The table also covers every class code, including the reserved one, and single and combined error flags on both sides. After the table, all 64 addresses are read back, which exposes a wrong base, a swapped offset, a stray write into an unused address and a dropped update. Directed cases cover same-cycle receive and transmit frames, which separate a correct queue from one that loses an event, and a read raised right behind a frame, which separates update priority from a read that slips in early. Exact grant timing and the order in which grant falls are also checked.

// File: rtl/stat_pkg.sv
package stat_pkg;
    localparam int ADDR_W  = 6;
    localparam int CNT_W   = 32;
    localparam int HALF_W  = CNT_W / 2;
    localparam int LEN_W   = 16;
    localparam int N_SLOT  = 8;
    localparam int SLOT_W  = $clog2(N_SLOT);
    localparam int OFS_W   = ADDR_W - 1;
    localparam int MIN_GAP = 34;

    // offsets inside one direction's half of the address space
    localparam logic [OFS_W-1:0] OFS_BYTES = 5'd0;
    localparam logic [OFS_W-1:0] OFS_PKTS  = 5'd1;
    localparam logic [OFS_W-1:0] OFS_BCAST = 5'd2;
    localparam logic [OFS_W-1:0] OFS_MCAST = 5'd3;
    localparam logic [OFS_W-1:0] OFS_UCAST = 5'd4;
    localparam logic [OFS_W-1:0] OFS_ERR0  = 5'd5;
    localparam logic [OFS_W-1:0] OFS_PAUSE = 5'd16;

    typedef enum logic [1:0] {
        ENG_INIT,
        ENG_IDLE,
        ENG_UPD,
        ENG_HOST
    } eng_st_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [1:0]       cls;
        logic [2:0]       err;
        logic             pause;
    } frame_evt_t;

    function automatic logic [OFS_W-1:0] class_ofs(input logic [1:0] cls);
        case (cls)
            2'b10:   return OFS_BCAST;
            2'b01:   return OFS_MCAST;
            default: return OFS_UCAST;
        endcase
    endfunction

    function automatic logic [OFS_W-1:0] bin_ofs(input logic [LEN_W-1:0] len);
        if (len < 16'd64)        return 5'd8;
        else if (len == 16'd64)  return 5'd9;
        else if (len < 16'd128)  return 5'd10;
        else if (len < 16'd256)  return 5'd11;
        else if (len < 16'd512)  return 5'd12;
        else if (len < 16'd1024) return 5'd13;
        else if (len < 16'd1518) return 5'd14;
        else                     return 5'd15;
    endfunction
endpackage

// File: rtl/stat_ram.sv
module stat_ram #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata
);
    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/stat_evt_queue.sv
module stat_evt_queue
    import stat_pkg::*;
#(
    parameter int                AW   = ADDR_W,
    parameter int                CW   = CNT_W,
    parameter logic [ADDR_W-1:0] BASE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_valid,
    input  frame_evt_t    evt,
    output logic          req,
    output logic [AW-1:0] req_addr,
    output logic [CW-1:0] req_inc,
    input  logic          ack
);
    // mask bit: 0 bytes, 1 packets, 2 class, 3..5 errors, 6 length bin, 7 pause
    typedef struct packed {
        frame_evt_t       evt;
        logic [N_SLOT-1:0] mask;
    } qst_t;

    qst_t q, d;
    logic [SLOT_W-1:0] slot;
    logic              found;
    logic [OFS_W-1:0]  ofs;

    always_comb begin
        d     = q;
        slot  = '0;
        found = 1'b0;
        for (int i = 0; i < N_SLOT; i++) begin
            if (!found && q.mask[i]) begin
                slot  = SLOT_W'(i);
                found = 1'b1;
            end
        end
        case (slot)
            3'd0:    ofs = OFS_BYTES;
            3'd1:    ofs = OFS_PKTS;
            3'd2:    ofs = class_ofs(q.evt.cls);
            3'd3:    ofs = OFS_ERR0;
            3'd4:    ofs = OFS_ERR0 + 5'd1;
            3'd5:    ofs = OFS_ERR0 + 5'd2;
            3'd6:    ofs = bin_ofs(q.evt.len);
            default: ofs = OFS_PAUSE;
        endcase
        req      = |q.mask;
        req_addr = BASE + AW'(ofs);
        req_inc  = (slot == '0) ? CW'(q.evt.len) : CW'(1);
        if (ack) d.mask = q.mask & (q.mask - 1'b1);
        if (evt_valid) begin
            d.evt  = evt;
            d.mask = {evt.pause, 1'b1, evt.err, 3'b111};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // a new frame may only arrive once the previous one is fully written
    p_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (q.mask == '0));
    // an update is only taken from a non-empty queue
    p_ack_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> req);
    // every frame yields packet, class and bin updates
    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> (q.mask[1] && q.mask[2] && q.mask[6]));
endmodule

// File: rtl/stat_engine.sv
module stat_engine
    import stat_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CNT_W,
    parameter int HW = HALF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    q_req,
    input  logic [AW-1:0] q_addr [2],
    input  logic [CW-1:0] q_inc  [2],
    output logic [1:0]    q_ack,
    input  logic          host_apply,
    input  logic [AW-1:0] host_addr,
    output logic          host_grant,
    output logic [HW-1:0] host_lo,
    output logic [HW-1:0] host_hi,
    output logic          ram_re,
    output logic [AW-1:0] ram_raddr,
    input  logic [CW-1:0] ram_rdata,
    output logic          ram_we,
    output logic [AW-1:0] ram_waddr,
    output logic [CW-1:0] ram_wdata
);
    typedef struct packed {
        eng_st_e       st;
        logic [AW-1:0] addr;
        logic [CW-1:0] inc;
        logic          last_tx;
        logic          grant;
        logic [HW-1:0] lo;
        logic [HW-1:0] hi;
    } eng_t;

    eng_t q, d;
    logic pick_tx;

    always_comb begin
        d         = q;
        q_ack     = '0;
        ram_re    = 1'b0;
        ram_raddr = '0;
        ram_we    = 1'b0;
        ram_waddr = q.addr;
        ram_wdata = ram_rdata + q.inc;
        pick_tx   = q_req[1] && (!q_req[0] || !q.last_tx);
        case (q.st)
            ENG_INIT: begin
                ram_we    = 1'b1;
                ram_wdata = '0;
                d.addr    = q.addr + 1'b1;
                if (q.addr == '1) d.st = ENG_IDLE;
            end
            ENG_IDLE: begin
                if (|q_req) begin
                    ram_re          = 1'b1;
                    ram_raddr       = q_addr[pick_tx];
                    d.addr          = q_addr[pick_tx];
                    d.inc           = q_inc[pick_tx];
                    q_ack[pick_tx]  = 1'b1;
                    d.last_tx       = pick_tx;
                    d.st            = ENG_UPD;
                end else if (host_apply && !q.grant) begin
                    ram_re    = 1'b1;
                    ram_raddr = host_addr;
                    d.st      = ENG_HOST;
                end
            end
            ENG_UPD: begin
                ram_we = 1'b1;
                d.st   = ENG_IDLE;
            end
            default: begin
                d.lo    = ram_rdata[HW-1:0];
                d.hi    = ram_rdata[CW-1:HW];
                d.grant = host_apply;
                d.st    = ENG_IDLE;
            end
        endcase
        if (!host_apply) d.grant = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ENG_INIT;
        end else begin
            q <= d;
        end
    end

    assign host_grant = q.grant;
    assign host_lo    = q.lo;
    assign host_hi    = q.hi;

    // the write of an update goes back to the word read one cycle earlier
    p_rmw_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ENG_UPD) |-> (ram_waddr == $past(ram_raddr)));
    // a queued update always takes the RAM before a host read
    p_evt_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ENG_IDLE) && (|q_req)) |=> (q.st == ENG_UPD));
    // grant drops once apply is low
    p_grant_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !host_apply |=> !host_grant);
    // read value held while the handshake stays up
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_grant && host_apply) |=> ($stable(host_lo) && $stable(host_hi)));
    // grant only rises right after a host read of the RAM
    p_grant_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_grant) |-> ($past(q.st) == ENG_HOST));
endmodule

// File: rtl/stat_bank.sv
module stat_bank
    import stat_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CNT_W,
    parameter int HW = HALF_W,
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_frame_valid,
    input  logic [LW-1:0] rx_frame_len,
    input  logic [1:0]    rx_frame_class,
    input  logic          rx_crc_err,
    input  logic          rx_fifo_full,
    input  logic          rx_len_err,
    input  logic          rx_pause,
    input  logic          tx_frame_valid,
    input  logic [LW-1:0] tx_frame_len,
    input  logic [1:0]    tx_frame_class,
    input  logic          tx_jam_drop,
    input  logic          tx_underflow,
    input  logic          tx_overflow,
    input  logic          tx_pause,
    input  logic [AW-1:0] rd_addr,
    input  logic          rd_apply,
    output logic          rd_grant,
    output logic [HW-1:0] rd_data_lo,
    output logic [HW-1:0] rd_data_hi
);
    localparam int N_DIR    = 2;
    localparam int DIR_SPAN = 2 ** (AW - 1);

    logic             evt_v   [N_DIR];
    frame_evt_t       evt     [N_DIR];
    logic [N_DIR-1:0] q_req;
    logic [N_DIR-1:0] q_ack;
    logic [AW-1:0]    q_addr  [N_DIR];
    logic [CW-1:0]    q_inc   [N_DIR];

    logic          ram_re, ram_we;
    logic [AW-1:0] ram_raddr, ram_waddr;
    logic [CW-1:0] ram_rdata, ram_wdata;

    assign evt_v[0] = rx_frame_valid;
    assign evt[0]   = '{len: rx_frame_len, cls: rx_frame_class,
                        err: {rx_len_err, rx_fifo_full, rx_crc_err}, pause: rx_pause};
    assign evt_v[1] = tx_frame_valid;
    assign evt[1]   = '{len: tx_frame_len, cls: tx_frame_class,
                        err: {tx_overflow, tx_underflow, tx_jam_drop}, pause: tx_pause};

    for (genvar g = 0; g < N_DIR; g++) begin : g_dir
        stat_evt_queue #(
            .AW   (AW),
            .CW   (CW),
            .BASE (AW'(g * DIR_SPAN))
        ) u_queue (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_valid (evt_v[g]),
            .evt       (evt[g]),
            .req       (q_req[g]),
            .req_addr  (q_addr[g]),
            .req_inc   (q_inc[g]),
            .ack       (q_ack[g])
        );
    end

    stat_engine #(.AW(AW), .CW(CW), .HW(HW)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .q_req      (q_req),
        .q_addr     (q_addr),
        .q_inc      (q_inc),
        .q_ack      (q_ack),
        .host_apply (rd_apply),
        .host_addr  (rd_addr),
        .host_grant (rd_grant),
        .host_lo    (rd_data_lo),
        .host_hi    (rd_data_hi),
        .ram_re     (ram_re),
        .ram_raddr  (ram_raddr),
        .ram_rdata  (ram_rdata),
        .ram_we     (ram_we),
        .ram_waddr  (ram_waddr),
        .ram_wdata  (ram_wdata)
    );

    stat_ram #(.AW(AW), .DW(CW)) u_ram (
        .clk   (clk),
        .re    (ram_re),
        .raddr (ram_raddr),
        .rdata (ram_rdata),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata)
    );

    // grant is never up in the same cycle as reset release
    p_reset_grant_r1: assert property (@(posedge clk)
        !rst_n |=> !rd_grant);
endmodule

// File: tb/tb_stat_bank.sv
module tb_stat_bank;
    localparam int NV = 16;
    localparam int WD = 100000;

    // vector: {dir, class[1:0], err[2:0], pause, len[15:0]}
    localparam logic [22:0] VEC [NV] = '{
        {1'b0, 2'd0, 3'd0, 1'b0, 16'd63},
        {1'b0, 2'd1, 3'd0, 1'b0, 16'd64},
        {1'b0, 2'd2, 3'd0, 1'b0, 16'd65},
        {1'b0, 2'd3, 3'd1, 1'b0, 16'd127},
        {1'b0, 2'd0, 3'd2, 1'b0, 16'd128},
        {1'b0, 2'd2, 3'd4, 1'b0, 16'd1517},
        {1'b0, 2'd1, 3'd7, 1'b0, 16'd1518},
        {1'b0, 2'd0, 3'd0, 1'b1, 16'd64},
        {1'b1, 2'd0, 3'd0, 1'b0, 16'd255},
        {1'b1, 2'd1, 3'd1, 1'b0, 16'd256},
        {1'b1, 2'd2, 3'd2, 1'b0, 16'd511},
        {1'b1, 2'd3, 3'd4, 1'b0, 16'd512},
        {1'b1, 2'd0, 3'd0, 1'b1, 16'd1023},
        {1'b1, 2'd2, 3'd7, 1'b0, 16'd1024},
        {1'b1, 2'd0, 3'd0, 1'b0, 16'd9000},
        {1'b0, 2'd2, 3'd0, 1'b0, 16'd20}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_frame_valid = 0, tx_frame_valid = 0;
    logic [15:0] rx_frame_len = 0, tx_frame_len = 0;
    logic [1:0]  rx_frame_class = 0, tx_frame_class = 0;
    logic        rx_crc_err = 0, rx_fifo_full = 0, rx_len_err = 0, rx_pause = 0;
    logic        tx_jam_drop = 0, tx_underflow = 0, tx_overflow = 0, tx_pause = 0;
    logic [5:0]  rd_addr = 0;
    logic        rd_apply = 0;
    logic        rd_grant;
    logic [15:0] rd_data_lo, rd_data_hi;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;
    logic [31:0] exp_cnt [64];

    always #2.5 clk = ~clk;

    stat_bank dut (
        .clk(clk), .rst_n(rst_n),
        .rx_frame_valid(rx_frame_valid), .rx_frame_len(rx_frame_len),
        .rx_frame_class(rx_frame_class), .rx_crc_err(rx_crc_err),
        .rx_fifo_full(rx_fifo_full), .rx_len_err(rx_len_err), .rx_pause(rx_pause),
        .tx_frame_valid(tx_frame_valid), .tx_frame_len(tx_frame_len),
        .tx_frame_class(tx_frame_class), .tx_jam_drop(tx_jam_drop),
        .tx_underflow(tx_underflow), .tx_overflow(tx_overflow), .tx_pause(tx_pause),
        .rd_addr(rd_addr), .rd_apply(rd_apply), .rd_grant(rd_grant),
        .rd_data_lo(rd_data_lo), .rd_data_hi(rd_data_hi)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got=%0h exp=%0h", tag, what, got, exp);
        end
    endtask

    function automatic string req_of(input int a);
        int o = a % 32;
        if (o <= 1)       return "R4";
        else if (o <= 4)  return "R5";
        else if (o <= 7)  return "R7";
        else if (o <= 15) return "R6";
        else if (o == 16) return "R8";
        else              return "R11";
    endfunction

    function automatic int bin_of(input int len);
        if (len < 64)        return 8;
        else if (len == 64)  return 9;
        else if (len < 128)  return 10;
        else if (len < 256)  return 11;
        else if (len < 512)  return 12;
        else if (len < 1024) return 13;
        else if (len < 1518) return 14;
        else                 return 15;
    endfunction

    task automatic model(input bit dir, input int len, input logic [1:0] cls,
                         input logic [2:0] err, input bit pause);
        int b = dir ? 32 : 0;
        exp_cnt[b + 0] += 32'(len);
        exp_cnt[b + 1] += 1;
        if (cls == 2'b10)      exp_cnt[b + 2] += 1;
        else if (cls == 2'b01) exp_cnt[b + 3] += 1;
        else                   exp_cnt[b + 4] += 1;
        for (int k = 0; k < 3; k++) if (err[k]) exp_cnt[b + 5 + k] += 1;
        exp_cnt[b + bin_of(len)] += 1;
        if (pause) exp_cnt[b + 16] += 1;
    endtask

    task automatic drive(input bit dir, input logic [15:0] len, input logic [1:0] cls,
                         input logic [2:0] err, input bit pause);
        if (!dir) begin
            rx_frame_valid = 1; rx_frame_len = len; rx_frame_class = cls;
            {rx_len_err, rx_fifo_full, rx_crc_err} = err; rx_pause = pause;
        end else begin
            tx_frame_valid = 1; tx_frame_len = len; tx_frame_class = cls;
            {tx_overflow, tx_underflow, tx_jam_drop} = err; tx_pause = pause;
        end
        model(dir, int'(len), cls, err, pause);
    endtask

    task automatic clear_evt();
        rx_frame_valid = 0; tx_frame_valid = 0;
    endtask

    // read a counter; n = rising edges from apply to grant seen
    task automatic host_read(input logic [5:0] a, output logic [31:0] v, output int n);
        @(negedge clk);
        rd_addr = a;
        rd_apply = 1;
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!rd_grant && n < 60);
        v = {rd_data_hi, rd_data_lo};
        rd_apply = 0;
        @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=%0d exp<%0d cycles", cyc, WD);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        int n;
        for (int i = 0; i < 64; i++) exp_cnt[i] = 0;

        repeat (4) @(negedge clk);
        chk("R1", "grant in reset", 32'(rd_grant), 0);
        rst_n = 1;
        repeat (80) @(negedge clk);
        chk("R1", "grant after reset", 32'(rd_grant), 0);
        host_read(6'h01, v, n);
        chk("R1", "rx packets after reset", v, 0);
        host_read(6'h30, v, n);
        chk("R1", "tx pause after reset", v, 0);

        // R2 latency and hold, R3 drop
        @(negedge clk);
        rd_addr = 6'h04;
        rd_apply = 1;
        @(posedge clk); @(negedge clk);
        chk("R2", "grant after one edge", 32'(rd_grant), 0);
        @(posedge clk); @(negedge clk);
        chk("R2", "grant after two edges", 32'(rd_grant), 1);
        v = {rd_data_hi, rd_data_lo};
        repeat (3) @(negedge clk);
        chk("R2", "value held", {rd_data_hi, rd_data_lo}, v);
        chk("R2", "grant held", 32'(rd_grant), 1);
        rd_apply = 0;
        @(posedge clk); @(negedge clk);
        chk("R3", "grant falls", 32'(rd_grant), 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][22], VEC[i][15:0], VEC[i][21:20], VEC[i][19:17], VEC[i][16]);
            @(negedge clk);
            clear_evt();
            repeat (40) @(negedge clk);
        end

        // R9: both directions in the same cycle
        @(negedge clk);
        drive(1'b0, 16'd300, 2'b01, 3'b010, 1'b0);
        drive(1'b1, 16'd700, 2'b10, 3'b001, 1'b1);
        @(negedge clk);
        clear_evt();
        repeat (40) @(negedge clk);
        host_read(6'h00, v, n);
        chk("R9", "rx bytes after joint frames", v, exp_cnt[0]);
        host_read(6'h20, v, n);
        chk("R9", "tx bytes after joint frames", v, exp_cnt[32]);

        // full readback of every address
        for (int a = 0; a < 64; a++) begin
            host_read(6'(a), v, n);
            chk(req_of(a), $sformatf("counter %0h", a), v, exp_cnt[a]);
        end

        // R10: read raised right behind a frame
        @(negedge clk);
        drive(1'b0, 16'd100, 2'b00, 3'b000, 1'b0);
        @(negedge clk);
        clear_evt();
        host_read(6'h00, v2, n);
        chk("R10", "rx bytes read behind frame", v2, exp_cnt[0]);
        total++;
        if (n <= 2) begin
            bad++;
            $display("FAIL R10 grant latency: got=%0d exp>2", n);
        end
        repeat (40) @(negedge clk);
        host_read(6'h0a, v, n);
        chk("R10", "bin after read", v, exp_cnt[10]);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule